// File: doc/BRIEF.md
# Gated 16-bit Timer with Tear-free Byte Access

This block is a 16-bit up-counter that software reaches through a byte-wide register port. Each count step is triggered either by every system clock cycle or by rising edges of an external clock pin. The steps pass through a prescaler that divides them by 1, 2, 4 or 8. A gate pin with selectable polarity can freeze the count, and a run bit stops it outright. When the counter wraps from its maximum value to zero, a sticky overflow flag is raised and also driven on a dedicated output.

Because the count is 16 bits wide and the port is 8 bits wide, a wide-access mode is provided. In that mode, reading the low byte captures the high byte into a holding register, and the high-byte address then reads that register. Writing the high-byte address only fills the holding register, and the following low-byte write loads both bytes in one cycle. Software therefore never sees or creates a half-updated count.

The external clock and gate pins are asynchronous and pass through two-flop synchronizers. The reset input is asserted asynchronously and released in step with the clock.

Top module: `gtimer16`

## Requirements
- R1: After reset, all four registers read 0x00 and `ovf_flag_o` is 0.
- R2: Register addresses are 0 = control, 1 = gate, 2 = count low, 3 = count high. The control fields are: bit 0 run, bit 1 wide mode, bit 2 external source, bits 4:3 prescale select, bit 7 overflow. The gate fields are: bit 7 gate enable, bit 6 gate polarity. Unused bits read 0. With wide mode clear, both count addresses read and write the live count bytes.
- R3: With wide mode set, a read of the low byte copies the live high byte into a holding register, and a read of the high-byte address returns that holding register, not the live byte.
- R4: With wide mode set, a write to the high-byte address changes only the holding register. A write to the low byte loads the low byte from the data and the live high byte from the holding register in the same cycle.
- R5: Each enabled step is divided by 2^sel, where sel is control bits 4:3. With the internal source, every clock cycle is a step.
- R6: A write to the low byte clears the prescaler. A write to the high-byte address leaves it untouched.
- R7: With the external source, the counter takes one step per rising edge of `ext_clk_i`, counted after a two-flop synchronizer. A steady level produces no steps.
- R8: With gate enable set, steps pass only while the synchronized gate level equals the polarity bit: polarity 0 counts while the gate is low and holds while it is high. With gate enable clear, the gate pin has no effect.
- R9: With run clear, the count holds its value.
- R10: A wrap from 0xFFFF to 0x0000 sets the overflow flag, which is visible at control bit 7 and on `ovf_flag_o`. The flag stays set until control is written with bit 7 = 0. Writing 1 to that bit leaves the flag unchanged.
- R11: In a cycle that writes a live count byte, the write takes the place of that cycle's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| gate_i | input | 1 | Gate pin, asynchronous |
| reg_rdata | output | 8 | Read data, valid while `reg_rd_en` is high, 0 otherwise |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench drives a low-byte read in wide mode exactly as the count crosses 0x00FF into 0x0100. A design that does not capture the high byte during that read returns 0x01 with a low byte of 0xFF, which is a torn value. A wide-mode high-byte write is followed by a switch back to byte mode to observe the live high byte. A design that writes the live byte directly shows the new value there too early. The prescaler is checked at every divide ratio. It is also checked by a high-byte write placed one step before a prescaler carry, and by a low-byte write placed one step before a carry. A design that clears on the wrong write gains or loses a count. Finally, a count write placed in a counting cycle exposes a design that applies both the write and the increment, because the result is off by one.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CNT_W     = 2 * BYTE_W;
  localparam int unsigned PSC_SEL_W = 2;
  localparam int unsigned PSC_W     = (1 << PSC_SEL_W) - 1;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_GATE   = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_CNT_HI = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PSC_SEL_W-1:0] psc_sel;
    logic                 ext_src;
    logic                 wide;
    logic                 run;
  } ctrl_cfg_t;

  typedef struct packed {
    logic en;
    logic pol;
  } gate_cfg_t;

endpackage

// File: rtl/gtm_sync.sv
module gtm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gtm_prescaler.sv
module gtm_prescaler
  import gtimer_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 clr_i,
  input  logic [PSC_SEL_W-1:0] sel_i,
  output logic                 carry_o
);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_d;
  logic [PSC_W-1:0] lim;
  logic             at_lim;

  always_comb begin
    lim     = ~({PSC_W{1'b1}} << sel_i);
    at_lim  = (psc_q == lim);
    carry_o = tick_i && !clr_i && at_lim;
    psc_d   = psc_q;
    if (clr_i)        psc_d = '0;
    else if (tick_i)  psc_d = at_lim ? '0 : psc_q + PSC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= psc_d;
  end

  AST_PSC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (psc_q == '0)); // R6

  AST_PSC_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(psc_q)); // R5

endmodule

// File: rtl/gtm_count_core.sv
module gtm_count_core
  import gtimer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wide_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              rd_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ovf_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [BYTE_W-1:0] hibuf_o,
  output logic              ovf_o
);

  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic [BYTE_W-1:0] hibuf_q, hibuf_d;
  logic              ovf_q,   ovf_d;
  logic              wr_hi_live;
  logic              wr_any;
  logic              inc_eff;
  logic              wrap;
  logic [CNT_W-1:0]  cnt_inc;

  always_comb begin
    wr_hi_live = wr_hi_i && !wide_i;
    wr_any     = wr_lo_i || wr_hi_live;
    inc_eff    = inc_i && !wr_any;
    cnt_inc    = cnt_q + CNT_W'(1);
    wrap       = inc_eff && (cnt_q == {CNT_W{1'b1}});

    cnt_d = cnt_q;
    if (inc_eff) cnt_d = cnt_inc;
    if (wr_lo_i) begin
      cnt_d[BYTE_W-1:0] = wdata_i;
      if (wide_i) cnt_d[CNT_W-1:BYTE_W] = hibuf_q;
    end
    if (wr_hi_live) cnt_d[CNT_W-1:BYTE_W] = wdata_i;

    hibuf_d = hibuf_q;
    if (wide_i && wr_hi_i)      hibuf_d = wdata_i;
    else if (wide_i && rd_lo_i) hibuf_d = cnt_q[CNT_W-1:BYTE_W];

    ovf_d = wrap || (ovf_q && !ovf_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      hibuf_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      hibuf_q <= hibuf_d;
      ovf_q   <= ovf_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign hibuf_o = hibuf_q;
  assign ovf_o   = ovf_q;

  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_lo_i && !(wr_hi_i && !wide_i)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_lo_i && !(wr_hi_i && !wide_i)) |=> $stable(cnt_q)); // R9

  AST_BUF_SNAPSHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && rd_lo_i && !wr_hi_i) |=> (hibuf_q == $past(cnt_q[CNT_W-1:BYTE_W]))); // R3

  AST_WIDE_HI_BUF_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && wr_hi_i) |=> (hibuf_q == $past(wdata_i))); // R4

  AST_WIDE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && wr_lo_i) |=> (cnt_q == {$past(hibuf_q), $past(wdata_i)})); // R4

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && wr_lo_i && !wr_hi_i) |=> (cnt_q == {$past(cnt_q[CNT_W-1:BYTE_W]), $past(wdata_i)})); // R11

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_lo_i && !(wr_hi_i && !wide_i) && (cnt_q == {CNT_W{1'b1}})) |=> ovf_q); // R10

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q); // R10

endmodule

// File: rtl/gtimer16.sv
module gtimer16
  import gtimer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr_en,
  input  logic       reg_rd_en,
  input  logic [7:0] reg_wdata,
  input  logic       ext_clk_i,
  input  logic       gate_i,
  output logic [7:0] reg_rdata,
  output logic       ovf_flag_o
);

  logic              rst_ni;
  logic              ext_lvl;
  logic              ext_prev_q;
  logic              ext_rise;
  logic              gate_lvl;
  reg_sel_e          sel;
  logic              wr_ctrl, wr_gate, wr_lo, wr_hi, rd_lo;
  ctrl_cfg_t         ctrl_q, ctrl_d;
  gate_cfg_t         gate_q, gate_d;
  logic              tick_src;
  logic              gate_open;
  logic              cnt_tick;
  logic              psc_carry;
  logic              ovf_clr;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] hibuf;
  logic              ovf;

  // reset: asserted asynchronously, released on a clock edge
  gtm_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i(clk), .rst_ni(rst_n), .d_i(1'b1), .q_o(rst_ni)
  );

  gtm_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i(clk), .rst_ni(rst_ni), .d_i(ext_clk_i), .q_o(ext_lvl)
  );

  gtm_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk_i(clk), .rst_ni(rst_ni), .d_i(gate_i), .q_o(gate_lvl)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= 1'b0;
    else         ext_prev_q <= ext_lvl;
  end

  // register decode
  always_comb begin
    sel     = reg_sel_e'(reg_addr);
    wr_ctrl = reg_wr_en && (sel == REG_CTRL);
    wr_gate = reg_wr_en && (sel == REG_GATE);
    wr_lo   = reg_wr_en && (sel == REG_CNT_LO);
    wr_hi   = reg_wr_en && (sel == REG_CNT_HI);
    rd_lo   = reg_rd_en && (sel == REG_CNT_LO);
    ovf_clr = wr_ctrl && !reg_wdata[7];
  end

  // configuration next state
  always_comb begin
    ctrl_d = ctrl_q;
    gate_d = gate_q;
    if (wr_ctrl) begin
      ctrl_d.psc_sel = reg_wdata[4:3];
      ctrl_d.ext_src = reg_wdata[2];
      ctrl_d.wide    = reg_wdata[1];
      ctrl_d.run     = reg_wdata[0];
    end
    if (wr_gate) begin
      gate_d.en  = reg_wdata[7];
      gate_d.pol = reg_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      gate_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      gate_q <= gate_d;
    end
  end

  // step qualification
  always_comb begin
    ext_rise  = ext_lvl && !ext_prev_q;
    tick_src  = ctrl_q.ext_src ? ext_rise : 1'b1;
    gate_open = !gate_q.en || (gate_lvl == gate_q.pol);
    cnt_tick  = ctrl_q.run && tick_src && gate_open;
  end

  gtm_prescaler u_psc (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .tick_i (cnt_tick),
    .clr_i  (wr_lo),
    .sel_i  (ctrl_q.psc_sel),
    .carry_o(psc_carry)
  );

  gtm_count_core u_core (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .inc_i    (psc_carry),
    .wide_i   (ctrl_q.wide),
    .wr_lo_i  (wr_lo),
    .wr_hi_i  (wr_hi),
    .rd_lo_i  (rd_lo),
    .wdata_i  (reg_wdata),
    .ovf_clr_i(ovf_clr),
    .cnt_o    (cnt),
    .hibuf_o  (hibuf),
    .ovf_o    (ovf)
  );

  // read data
  always_comb begin
    reg_rdata = '0;
    if (reg_rd_en) begin
      unique case (sel)
        REG_CTRL:   reg_rdata = {ovf, 2'b00, ctrl_q.psc_sel, ctrl_q.ext_src,
                                 ctrl_q.wide, ctrl_q.run};
        REG_GATE:   reg_rdata = {gate_q.en, gate_q.pol, 6'b000000};
        REG_CNT_LO: reg_rdata = cnt[BYTE_W-1:0];
        REG_CNT_HI: reg_rdata = ctrl_q.wide ? hibuf : cnt[CNT_W-1:BYTE_W];
        default:    reg_rdata = '0;
      endcase
    end
  end

  assign ovf_flag_o = ovf;

  AST_RUN_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctrl_q.run |-> !psc_carry); // R9

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ni)
    (gate_q.en && (gate_lvl != gate_q.pol)) |-> !psc_carry); // R8

  AST_EXT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q.ext_src && ext_rise) |=> !ext_rise); // R7

  AST_OVF_PIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovf_clr && !psc_carry) |=> !ovf_flag_o); // R10

endmodule

// File: tb/tb_gtimer16.sv
module tb_gtimer16;

  localparam int HALF_PERIOD = 4; // 8 time units per cycle, 125 MHz at 1 ns units

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr_en;
  logic       reg_rd_en;
  logic [7:0] reg_wdata;
  logic       ext_clk_i;
  logic       gate_i;
  logic [7:0] reg_rdata;
  logic       ovf_flag_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  gtimer16 dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata), .ext_clk_i(ext_clk_i),
    .gate_i(gate_i), .reg_rdata(reg_rdata), .ovf_flag_o(ovf_flag_o)
  );

  always #HALF_PERIOD clk = ~clk;

  // monitor: pops expected read data as each read cycle completes
  always @(negedge clk) begin
    if (reg_rd_en) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", t, reg_rdata, e);
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_addr = a; reg_rd_en = 1'b1;
    @(posedge clk); #1;
    reg_rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chk_pin(input string t, input logic act, input logic e);
    @(negedge clk);
    n_checks++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", t, act, e);
    end
    @(posedge clk); #1;
  endtask

  // run with internal source for n_cycles steps starting from count 0
  task automatic run_steps(input logic [7:0] cfg, input int n_idle);
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd3, 8'h00);
    bus_wr(2'd0, cfg | 8'h01);
    idle(n_idle);
    bus_wr(2'd0, cfg & 8'hFE);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    reg_wdata = '0; ext_clk_i = 1'b0; gate_i = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(5);

    // R1 reset state
    bus_rd(2'd0, 8'h00, "R1 ctrl");
    bus_rd(2'd1, 8'h00, "R1 gate");
    bus_rd(2'd2, 8'h00, "R1 lo");
    bus_rd(2'd3, 8'h00, "R1 hi");
    chk_pin("R1 ovf pin", ovf_flag_o, 1'b0);

    // R2 byte mode direct access and field layout
    bus_wr(2'd3, 8'hA5);
    bus_wr(2'd2, 8'h3C);
    bus_rd(2'd2, 8'h3C, "R2 lo");
    bus_rd(2'd3, 8'hA5, "R2 hi");
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, 8'hC0, "R2 gate unused bits");
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'hF8);
    bus_rd(2'd0, 8'h18, "R2 ctrl fields");
    bus_wr(2'd0, 8'h80);

    // R4 wide high write reaches only the holding register
    bus_wr(2'd0, 8'h82);
    bus_wr(2'd3, 8'h12);
    bus_wr(2'd0, 8'h80);
    bus_rd(2'd3, 8'hA5, "R4 live hi untouched");
    bus_wr(2'd0, 8'h82);
    bus_wr(2'd2, 8'h34);
    bus_rd(2'd2, 8'h34, "R4 commit lo");
    bus_rd(2'd3, 8'h12, "R4 commit hi via buffer");
    bus_wr(2'd0, 8'h80);
    bus_rd(2'd3, 8'h12, "R4 live hi after commit");

    // R3 snapshot held across a live change
    bus_wr(2'd0, 8'h82);
    bus_rd(2'd2, 8'h34, "R3 lo");
    bus_wr(2'd0, 8'h80);
    bus_wr(2'd3, 8'h55);
    bus_wr(2'd0, 8'h82);
    bus_rd(2'd3, 8'h12, "R3 hi from snapshot");

    // R3 tear-free across 0x00FF -> 0x0100 while running
    bus_wr(2'd3, 8'h00);
    bus_wr(2'd2, 8'hFE);
    bus_wr(2'd0, 8'h83);
    idle(1);
    bus_rd(2'd2, 8'hFF, "R3 lo before rollover");
    bus_wr(2'd0, 8'h82);
    bus_rd(2'd3, 8'h00, "R3 hi consistent with lo");
    bus_wr(2'd0, 8'h80);
    bus_rd(2'd3, 8'h01, "R3 live hi advanced");
    bus_rd(2'd2, 8'h01, "R3 live lo");

    // R9 hold while stopped
    idle(10);
    bus_rd(2'd2, 8'h01, "R9 hold");

    // R5 prescale ratios
    run_steps(8'h80, 4);
    bus_rd(2'd2, 8'h05, "R5 div1");
    run_steps(8'h88, 6);
    bus_rd(2'd2, 8'h03, "R5 div2");
    run_steps(8'h90, 9);
    bus_rd(2'd2, 8'h02, "R5 div4");
    run_steps(8'h98, 19);
    bus_rd(2'd2, 8'h02, "R5 div8");

    // R6 high write does not clear the prescaler
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd0, 8'h91);
    idle(2);
    bus_wr(2'd3, 8'h00);
    idle(1);
    bus_wr(2'd0, 8'h90);
    bus_rd(2'd2, 8'h01, "R6 hi write keeps prescaler");
    // R6 low write clears the prescaler
    bus_wr(2'd0, 8'h91);
    idle(1);
    bus_wr(2'd2, 8'h00);
    idle(2);
    bus_wr(2'd0, 8'h90);
    bus_rd(2'd2, 8'h00, "R6 lo write clears prescaler");

    // R11 write replaces the same-cycle increment
    bus_wr(2'd0, 8'h81);
    idle(2);
    bus_wr(2'd2, 8'h40);
    bus_wr(2'd0, 8'h80);
    bus_rd(2'd2, 8'h41, "R11 write wins");

    // R7 external clock edges
    bus_wr(2'd0, 8'h84);
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd0, 8'h85);
    idle(20);
    for (int k = 0; k < 5; k++) begin
      ext_clk_i = 1'b1; idle(4);
      ext_clk_i = 1'b0; idle(4);
    end
    idle(8);
    bus_wr(2'd0, 8'h84);
    bus_rd(2'd2, 8'h05, "R7 external edges");
    bus_wr(2'd0, 8'h80);

    // R8 gate polarity and enable
    gate_i = 1'b1; idle(5);
    bus_wr(2'd1, 8'h80);
    run_steps(8'h80, 9);
    bus_rd(2'd2, 8'h00, "R8 pol0 gate high holds");
    gate_i = 1'b0; idle(5);
    run_steps(8'h80, 9);
    bus_rd(2'd2, 8'h0A, "R8 pol0 gate low counts");
    bus_wr(2'd1, 8'hC0);
    run_steps(8'h80, 9);
    bus_rd(2'd2, 8'h00, "R8 pol1 gate low holds");
    gate_i = 1'b1; idle(5);
    run_steps(8'h80, 9);
    bus_rd(2'd2, 8'h0A, "R8 pol1 gate high counts");
    bus_wr(2'd1, 8'h00);
    gate_i = 1'b0; idle(5);
    run_steps(8'h80, 9);
    bus_rd(2'd2, 8'h0A, "R8 gate disabled free");

    // R10 overflow flag
    bus_wr(2'd3, 8'hFF);
    bus_wr(2'd2, 8'hFF);
    chk_pin("R10 no flag before wrap", ovf_flag_o, 1'b0);
    bus_wr(2'd0, 8'h81);
    bus_wr(2'd0, 8'h80);
    chk_pin("R10 flag pin set", ovf_flag_o, 1'b1);
    bus_rd(2'd0, 8'h80, "R10 flag in ctrl");
    bus_rd(2'd2, 8'h00, "R10 wrapped lo");
    bus_rd(2'd3, 8'h00, "R10 wrapped hi");
    bus_wr(2'd0, 8'h80);
    bus_rd(2'd0, 8'h80, "R10 write 1 keeps flag");
    bus_wr(2'd0, 8'h00);
    chk_pin("R10 flag pin cleared", ovf_flag_o, 1'b0);
    bus_rd(2'd0, 8'h00, "R10 flag cleared in ctrl");

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule